// File: doc/BRIEF.md
# Vector first-difference locator

This unit takes two vector operands, cuts them into elements of 8, 16 or 32 bits (picked per operation), and finds the lowest-numbered element where the two operands disagree. Element and byte numbering run from the most significant end, so byte 0 is the top byte of the operand. The answer is a byte offset, not an element index. The unit can also look for the first element of the first operand whose bits are all zero. In that case it reports whichever of the two events comes first.

The answer is placed, zero-extended, in the upper doubleword of a result vector, and the lower doubleword is zero. When the caller asks for it, the unit also returns a 2-bit condition code. The code tells whether nothing was found, whether a zero element came first, or whether the first operand's differing element is below or above the second operand's element in an unsigned comparison. An unsupported element size or a reserved modifier bit is flagged as a specification error, and no result is produced. All outputs are registered one cycle after the valid strobe.

Top module: `vec_first_diff`

## Requirements
- R1: While reset is held, and right after it, the result, the condition code, the code-valid flag and the error flag are all zero.
- R2: With size code 0 (8-bit elements), the cycle after a strobe the result bits 127:64 hold the byte offset of the first differing byte, where byte 0 is bits 127:120. Result bits 63:0 are zero.
- R3: With size code 1 (16-bit) or 2 (32-bit), the reported offset is the element number of the first difference multiplied by 2 or 4, so it is always a multiple of the element size in bytes.
- R4: When every element matches and no zero element is reported, the offset is 16.
- R5: When modifier bit 1 is set, the offset is the smaller of the first-difference offset and the offset of the first all-zero element of the first operand. When bit 1 is clear, zero elements have no effect.
- R6: The code-valid flag is high in the cycle after a strobe only if modifier bit 0 was set and there was no error. Otherwise it is low.
- R7: The condition code is 3 when neither a difference nor an enabled zero element exists. It is 0 when the zero element lies strictly before the first difference.
- R8: Otherwise the condition code is 1 if the first operand's differing element is unsigned-less than the second operand's element, and 2 if it is greater.
- R9: A size code above 2 raises the error flag for one cycle, keeps the code-valid flag low and leaves the result unchanged.
- R10: Any modifier bit above bit 1 being set gives the same error behaviour as R9.
- R11: In a cycle after no strobe, the code-valid and error flags are low and the result keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 128 | First operand; also searched for zero elements |
| opb | input | 128 | Second operand |
| elem_size | input | 4 | Element size code: 0 = 8, 1 = 16, 2 = 32 bits |
| modifier | input | 4 | Bit 0 = return condition code, bit 1 = zero search, others reserved |
| result | output | 128 | Offset in bits 127:64, zeros in bits 63:0 |
| cond_code | output | 2 | Condition code, meaningful when cc_valid is high |
| cc_valid | output | 1 | Condition code produced in this cycle |
| spec_err | output | 1 | Specification error for the previous strobe |

## Verification
The assertions assume that the strobe and the operation fields are driven at reset to known levels, and that the result is only read in the cycle after a strobe or in later idle cycles. The bench changes its inputs only on falling edges and holds the strobe for exactly one cycle, so each operation maps to one registered answer. The sweep places the injected mismatch and zero element at every byte position for every size and every legal modifier. Separate passes walk through every illegal size code and every reserved modifier pattern.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
   typedef enum logic [1:0] {
      CC_ZERO_FIRST = 2'd0,
      CC_A_BELOW    = 2'd1,
      CC_A_ABOVE    = 2'd2,
      CC_NONE       = 2'd3
   } vfd_cc_e;

   // supported element sizes: 1, 2 and 4 bytes (codes 0..2)
   localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/vfd_elem_scan.sv
// Per-element flags for one element size; element 0 is the most significant.
module vfd_elem_scan #(
   parameter int unsigned VEC_BYTES = 16,
   parameter int unsigned EB        = 1
) (
   input  logic [8*VEC_BYTES-1:0]  a_i,
   input  logic [8*VEC_BYTES-1:0]  b_i,
   output logic [VEC_BYTES/EB-1:0] diff_o,
   output logic [VEC_BYTES/EB-1:0] zero_o,
   output logic [VEC_BYTES/EB-1:0] lt_o
);
   localparam int unsigned N  = VEC_BYTES / EB;
   localparam int unsigned EW = 8 * EB;
   localparam int unsigned VW = 8 * VEC_BYTES;

   if (VEC_BYTES % EB != 0) begin : g_bad_size
      $error("vfd_elem_scan: VEC_BYTES must be a multiple of EB");
   end

   for (genvar i = 0; i < N; i++) begin : g_el
      logic [EW-1:0] ea;
      logic [EW-1:0] eb_v;
      assign ea        = a_i[VW-1-EW*i -: EW];
      assign eb_v      = b_i[VW-1-EW*i -: EW];
      assign diff_o[i] = |(ea ^ eb_v);
      assign zero_o[i] = ~|ea;
      assign lt_o[i]   = ea < eb_v;
   end
endmodule

// File: rtl/vfd_first_pick.sv
// Lowest-index set bit of a flag vector.
module vfd_first_pick #(
   parameter int unsigned N  = 16,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  hit_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   if (N < 2) begin : g_bad_n
      $error("vfd_first_pick: N must be at least 2");
   end

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/vec_first_diff.sv
module vec_first_diff
   import vfd_pkg::*;
#(
   parameter int unsigned VEC_BYTES = 16,
   parameter int unsigned ES_W      = 4,
   parameter int unsigned MOD_W     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [8*VEC_BYTES-1:0] opa,
   input  logic [8*VEC_BYTES-1:0] opb,
   input  logic [ES_W-1:0]        elem_size,
   input  logic [MOD_W-1:0]       modifier,
   output logic [8*VEC_BYTES-1:0] result,
   output logic [1:0]             cond_code,
   output logic                   cc_valid,
   output logic                   spec_err
);
   localparam int unsigned VEC_W  = 8 * VEC_BYTES;
   localparam int unsigned HALF_W = VEC_W / 2;
   localparam int unsigned POS_W  = $clog2(VEC_BYTES + 1);

   if (VEC_BYTES < 8 || (VEC_BYTES & (VEC_BYTES - 1)) != 0) begin : g_bad_vec
      $error("vec_first_diff: VEC_BYTES must be a power of two, at least 8");
   end
   if (ES_W < 2 || MOD_W < 3) begin : g_bad_fields
      $error("vec_first_diff: field widths too small");
   end

   logic [POS_W-1:0]     pos_m [NUM_SIZES];
   logic [POS_W-1:0]     pos_z [NUM_SIZES];
   logic [NUM_SIZES-1:0] below_at;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int unsigned EB = 1 << s;
      localparam int unsigned N  = VEC_BYTES / EB;
      localparam int unsigned IW = $clog2(N);

      logic [N-1:0]  diff, zero, lt;
      logic          f_m, f_z;
      logic [IW-1:0] i_m, i_z;

      vfd_elem_scan #(.VEC_BYTES(VEC_BYTES), .EB(EB)) u_scan (
         .a_i(opa), .b_i(opb), .diff_o(diff), .zero_o(zero), .lt_o(lt)
      );
      vfd_first_pick #(.N(N), .IW(IW)) u_pick_m (
         .hit_i(diff), .found_o(f_m), .idx_o(i_m)
      );
      vfd_first_pick #(.N(N), .IW(IW)) u_pick_z (
         .hit_i(zero), .found_o(f_z), .idx_o(i_z)
      );

      assign pos_m[s]    = f_m ? POS_W'(i_m) * POS_W'(EB) : POS_W'(VEC_BYTES);
      assign pos_z[s]    = f_z ? POS_W'(i_z) * POS_W'(EB) : POS_W'(VEC_BYTES);
      assign below_at[s] = f_m & lt[i_m];
   end

   logic             size_bad, mod_bad, spec;
   logic [POS_W-1:0] sel_m, sel_z, first_zero, hit_pos;
   logic             sel_below;
   vfd_cc_e          cc_next;

   assign size_bad = elem_size > ES_W'(NUM_SIZES - 1);
   assign mod_bad  = |modifier[MOD_W-1:2];
   assign spec     = size_bad | mod_bad;

   always_comb begin
      case (elem_size[1:0])
         2'd0:    begin sel_m = pos_m[0]; sel_z = pos_z[0]; sel_below = below_at[0]; end
         2'd1:    begin sel_m = pos_m[1]; sel_z = pos_z[1]; sel_below = below_at[1]; end
         default: begin sel_m = pos_m[2]; sel_z = pos_z[2]; sel_below = below_at[2]; end
      endcase
      first_zero = modifier[1] ? sel_z : POS_W'(VEC_BYTES);
      hit_pos    = (first_zero < sel_m) ? first_zero : sel_m;
      if (first_zero == POS_W'(VEC_BYTES) && sel_m == POS_W'(VEC_BYTES))
         cc_next = CC_NONE;
      else if (first_zero < sel_m)
         cc_next = CC_ZERO_FIRST;
      else if (sel_below)
         cc_next = CC_A_BELOW;
      else
         cc_next = CC_A_ABOVE;
   end

   logic [POS_W-1:0] pos_q;
   vfd_cc_e          cc_q;
   logic             ccv_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         cc_q  <= CC_ZERO_FIRST;
         ccv_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         ccv_q <= in_valid & ~spec & modifier[0];
         err_q <= in_valid & spec;
         if (in_valid && !spec) begin
            pos_q <= hit_pos;
            if (modifier[0]) cc_q <= cc_next;
         end
      end
   end

   assign result    = {HALF_W'(pos_q), {HALF_W{1'b0}}};
   assign cond_code = cc_q;
   assign cc_valid  = ccv_q;
   assign spec_err  = err_q;

   // R9 / R10: an error never comes with a code and never changes the result
   p_err_no_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spec_err |-> !cc_valid);
   p_err_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      spec_err |-> $stable(result));
   // R11: idle cycles leave everything quiet
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && !cc_valid && !spec_err));
   // R7: code 3 exactly pairs with the no-hit offset
   p_none_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_valid && cond_code == 2'd3) |-> (result[VEC_W-1:HALF_W] == HALF_W'(VEC_BYTES)));
   p_hit_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_valid && cond_code != 2'd3) |-> (result[VEC_W-1:HALF_W] < HALF_W'(VEC_BYTES)));
   // R3: word-sized elements give word-aligned offsets
   p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !spec && elem_size == ES_W'(2)) |=> (result[HALF_W+1:HALF_W] == 2'b00));
   // R5: with zero search off, the answer is the mismatch offset
   p_no_zero_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !spec && !modifier[1]) |=> (pos_q == $past(sel_m)));
endmodule

// File: tb/vec_first_diff_test.sv
module vec_first_diff_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [127:0] opa, opb;
   logic [3:0]   elem_size, modifier;
   logic [127:0] result;
   logic [1:0]   cond_code;
   logic         cc_valid, spec_err;

   int           checks = 0;
   int           failures = 0;
   logic [127:0] last_res = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_first_diff uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
      .elem_size(elem_size), .modifier(modifier), .result(result),
      .cond_code(cond_code), .cc_valid(cc_valid), .spec_err(spec_err)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                 input int es, input logic [3:0] md,
                                 output int pos, output int cc);
      int eb = 1 << es;
      int n = 16 / eb;
      int fm = 16;
      int fz = 16;
      bit below = 1'b0;
      logic [31:0] mask = (eb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * eb)) - 32'd1);
      logic [31:0] ea, ebv;
      for (int i = n - 1; i >= 0; i--) begin
         ea  = 32'(a >> (128 - 8 * eb * (i + 1))) & mask;
         ebv = 32'(b >> (128 - 8 * eb * (i + 1))) & mask;
         if (ea != ebv) begin
            fm = i * eb;
            below = ea < ebv;
         end
         if (md[1] && ea == 32'd0) fz = i * eb;
      end
      pos = (fz < fm) ? fz : fm;
      if (fm == 16 && fz == 16) cc = 3;
      else if (fz < fm) cc = 0;
      else cc = below ? 1 : 2;
   endfunction

   task automatic do_op(input logic [127:0] a, input logic [127:0] b,
                        input logic [3:0] es, input logic [3:0] md, input string tag);
      int pos, cc;
      logic [127:0] exp;
      @(negedge clk);
      opa = a; opb = b; elem_size = es; modifier = md; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (es > 4'd2 || md[3:2] != 2'b00) begin
         chk({tag, " error flag"}, 128'(spec_err), 128'd1);
         chk({tag, " no code on error"}, 128'(cc_valid), 128'd0);
         chk({tag, " result unchanged"}, result, last_res);
      end else begin
         model(a, b, int'(es), md, pos, cc);
         exp = {64'(pos), 64'd0};
         chk({tag, " offset"}, result, exp);
         chk("R6 code-valid", 128'(cc_valid), 128'(md[0]));
         chk("R9 no error", 128'(spec_err), 128'd0);
         if (md[0]) begin
            if (cc == 0 || cc == 3) chk("R7 code", 128'(cond_code), 128'(cc));
            else                    chk("R8 code", 128'(cond_code), 128'(cc));
         end
         last_res = exp;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [127:0] a, b;
      rst_n = 1'b0; in_valid = 1'b0; opa = '0; opb = '0;
      elem_size = '0; modifier = '0;
      repeat (3) @(negedge clk);
      chk("R1 result", result, 128'd0);
      chk("R1 code", 128'(cond_code), 128'd0);
      chk("R1 code-valid", 128'(cc_valid), 128'd0);
      chk("R1 error", 128'(spec_err), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", result, 128'd0);

      // sweep: mismatch byte k and zero byte z at every position
      for (int es = 0; es < 3; es++) begin
         for (int md = 0; md < 4; md++) begin
            for (int k = 0; k <= 16; k++) begin
               for (int z = 0; z <= 16; z++) begin
                  int eb = 1 << es;
                  string tag;
                  for (int j = 0; j < 16; j++) a[127-8*j -: 8] = 8'($urandom_range(1, 255));
                  b = a;
                  if (z < 16) begin
                     for (int j = (z / eb) * eb; j < (z / eb) * eb + eb; j++) begin
                        a[127-8*j -: 8] = 8'h00;
                        b[127-8*j -: 8] = 8'h00;
                     end
                  end
                  if (k < 16) b[127-8*k -: 8] = b[127-8*k -: 8] ^ 8'($urandom_range(1, 255));
                  if (md[1]) tag = "R5";
                  else if (k == 16) tag = "R4";
                  else if (es == 0) tag = "R2";
                  else tag = "R3";
                  do_op(a, b, 4'(es), 4'(md), tag);
               end
            end
         end
      end

      // R8: unsigned verdict on a top-bit difference
      a = '0; b = '0;
      a[127:96] = 32'h8000_0000; b[127:96] = 32'h7FFF_FFFF;
      do_op(a, b, 4'd2, 4'd1, "R8 unsigned above");
      do_op(b, a, 4'd2, 4'd1, "R8 unsigned below");
      // R4: identical operands, no zero search
      a = {16{8'h5A}};
      do_op(a, a, 4'd1, 4'd1, "R4 all equal");

      // R11: idle cycle after an operation
      @(negedge clk);
      chk("R11 result holds", result, last_res);
      chk("R11 code-valid low", 128'(cc_valid), 128'd0);
      chk("R11 error low", 128'(spec_err), 128'd0);

      // R9: every illegal size code
      for (int es = 3; es < 16; es++) do_op({8{16'h1234}}, '0, 4'(es), 4'd1, "R9");
      // R10: every reserved modifier pattern
      for (int md = 4; md < 16; md++) do_op({8{16'h00FF}}, '1, 4'd0, 4'(md), "R10");

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule